// File: doc/BRIEF.md
# Direct-Mapped Read Cache

This block is a read-only cache placed between a single requester and a word-wide backing memory. It holds 16 KB of data as 1024 lines. Each line has four 32-bit words, and each line keeps its own valid flag and stored tag. Every request carries a 32-bit byte address, which the cache cuts into three unsigned fields:

- an 18-bit tag in bits 31:14,
- a 10-bit line index in bits 13:4,
- a 4-bit byte offset in bits 3:0.

A request whose line is valid and whose stored tag equals the address tag is served from the cache. Any other request first pulls the whole line from memory, writes it into the cache and then answers. Every answer carries the word and a code for how the access went.

The controller is a four-state machine:

- `ST_IDLE` accepts a request and moves to `ST_LOOKUP`.
- `ST_LOOKUP` compares tags. On a hit it answers and returns to `ST_IDLE`. On a miss it records whether the line was empty or held another tag, then enters `ST_FILL`.
- `ST_FILL` reads the four words of the line in ascending order. It leaves for `ST_RESPOND` once the last word has arrived and the line, tag and valid flag have been installed.
- `ST_RESPOND` answers from the freshly written line and returns to `ST_IDLE`.

Only one request is in flight at a time.

Top module: `dm_read_cache`

## Requirements
- R1: After reset every line is invalid, `req_ready` is 1, and `resp_valid` and `mem_rd` are 0. The first access to any line is therefore reported as a cold miss.
- R2: Address bits 31:14 form the tag, bits 13:4 the line index and bits 3:0 the byte offset, all read as unsigned values. Lines with different indices never disturb each other.
- R3: An access whose line is valid with a matching tag is a hit. It reports `resp_kind` = 2'b00, performs no memory read, and raises `resp_valid` in the cycle right after the request is accepted.
- R4: An access to an invalid line reports `resp_kind` = 2'b01 after a refill. A later access to any word of that line is a hit.
- R5: An access to a valid line holding a different tag reports `resp_kind` = 2'b10. The old line is overwritten, so going back to the old tag replaces the line again (code 2'b10).
- R6: A refill makes exactly four word reads, at the line base address plus 0, 4, 8 and 12, in that order. `mem_addr` is word aligned and held steady while `mem_rd` waits for `mem_rvalid`. `req_ready` stays 0 for the whole refill.
- R7: `resp_data` always equals the backing-memory word at the requested address, whatever the outcome.
- R8: Address bits 1:0 do not affect the returned word. Bits 3:2 pick the word in the line: value k selects the word at line base + 4k.
- R9: At most one request is outstanding. `req_ready` is 0 from the acceptance of a request until after its response. `resp_valid` is a single-cycle pulse. A request held asserted across a response is accepted only in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Read request present |
| req_ready | output | 1 | Cache can accept a request this cycle |
| req_addr | input | 32 | Byte address of the request |
| resp_valid | output | 1 | One-cycle pulse: response valid |
| resp_data | output | 32 | Word read for the request |
| resp_kind | output | 2 | 00 hit, 01 cold miss, 10 miss with replacement |
| mem_rd | output | 1 | Word read to backing memory pending |
| mem_addr | output | 32 | Word-aligned byte address of the pending memory read |
| mem_rvalid | input | 1 | Backing memory returns the pending word this cycle |
| mem_rdata | input | 32 | Word returned by the backing memory |

## Verification
Two events can fall in the same cycle: the response of one access and the presentation of the next request. The most telling case is when the next request targets the line that was just refilled.

To provoke it, the bench keeps `req_valid` high straight through a cold-miss refill, with the address already changed to another word of the same line. It judges the result at the ports:

- `req_ready` must stay low in every refill cycle and in the response cycle.
- The held request must be accepted only in the cycle after the pulse.
- It must then come back one cycle later as a hit carrying the memory word of its own address.

// File: rtl/dmc_pkg.sv
package dmc_pkg;

    typedef enum logic [1:0] {
        KIND_HIT  = 2'b00,
        KIND_COLD = 2'b01,
        KIND_REPL = 2'b10
    } kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_FILL,
        ST_RESPOND
    } state_e;

endpackage

// File: rtl/dmc_addr_split.sv
module dmc_addr_split #(
    parameter int ADDR_W = 32,
    parameter int IDX_W  = 10,
    parameter int WSEL_W = 2,
    parameter int BYTE_W = 2,
    parameter int TAG_W  = ADDR_W - IDX_W - WSEL_W - BYTE_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [TAG_W-1:0]  tag,
    output logic [IDX_W-1:0]  idx,
    output logic [WSEL_W-1:0] wsel
);
    localparam int IDX_LO  = WSEL_W + BYTE_W;
    localparam int TAG_LO  = IDX_LO + IDX_W;

    logic unused_byte_bits;

    assign tag  = addr[ADDR_W-1:TAG_LO];
    assign idx  = addr[TAG_LO-1:IDX_LO];
    assign wsel = addr[IDX_LO-1:BYTE_W];
    assign unused_byte_bits = ^addr[BYTE_W-1:0];

endmodule

// File: rtl/dmc_tag_store.sv
module dmc_tag_store #(
    parameter int LINES = 1024,
    parameter int TAG_W = 18,
    parameter int IDX_W = $clog2(LINES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_valid,
    output logic [TAG_W-1:0] rd_tag,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag
);
    logic [LINES-1:0] valid_q;
    logic [TAG_W-1:0] tag_q [LINES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
        end
    end

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];

endmodule

// File: rtl/dmc_line_store.sv
module dmc_line_store #(
    parameter int LINES  = 1024,
    parameter int LINE_W = 128,
    parameter int IDX_W  = $clog2(LINES)
) (
    input  logic              clk,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [LINE_W-1:0] rd_line,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [LINE_W-1:0] wr_line
);
    logic [LINE_W-1:0] line_q [LINES];

    always_ff @(posedge clk) begin
        if (wr_en) begin
            line_q[wr_idx] <= wr_line;
        end
    end

    assign rd_line = line_q[rd_idx];

endmodule

// File: rtl/dmc_fsm.sv
module dmc_fsm
    import dmc_pkg::*;
#(
    parameter int WORDS  = 4,
    parameter int BEAT_W = $clog2(WORDS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              line_hit,
    input  logic              line_valid,
    input  logic              mem_rvalid,
    output logic              req_ready,
    output logic              take_req,
    output logic              resp_valid,
    output logic [1:0]        resp_kind,
    output logic              mem_rd,
    output logic              beat_take,
    output logic              install,
    output logic [BEAT_W-1:0] beat
);
    localparam logic [BEAT_W-1:0] LAST_BEAT = BEAT_W'(WORDS - 1);

    state_e state_q, state_d;
    logic [BEAT_W-1:0] beat_q;
    kind_e kind_q;
    logic last_beat;

    assign last_beat = (beat_q == LAST_BEAT);
    assign beat      = beat_q;

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (req_valid) state_d = ST_LOOKUP;
            ST_LOOKUP:  state_d = line_hit ? ST_IDLE : ST_FILL;
            ST_FILL:    if (mem_rvalid && last_beat) state_d = ST_RESPOND;
            ST_RESPOND: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Outputs decoded from the state
    always_comb begin
        req_ready  = 1'b0;
        take_req   = 1'b0;
        resp_valid = 1'b0;
        resp_kind  = KIND_HIT;
        mem_rd     = 1'b0;
        beat_take  = 1'b0;
        install    = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                req_ready = 1'b1;
                take_req  = req_valid;
            end
            ST_LOOKUP: begin
                resp_valid = line_hit;
                resp_kind  = KIND_HIT;
            end
            ST_FILL: begin
                mem_rd    = 1'b1;
                beat_take = mem_rvalid;
                install   = mem_rvalid && last_beat;
            end
            ST_RESPOND: begin
                resp_valid = 1'b1;
                resp_kind  = kind_q;
            end
        endcase
    end

    // Miss classification and beat counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            beat_q <= '0;
            kind_q <= KIND_HIT;
        end else begin
            if (state_q == ST_LOOKUP && !line_hit) begin
                beat_q <= '0;
                kind_q <= line_valid ? KIND_REPL : KIND_COLD;
            end else if (state_q == ST_FILL && mem_rvalid) begin
                beat_q <= beat_q + 1'b1;
            end
        end
    end

endmodule

// File: rtl/dm_read_cache.sv
module dm_read_cache #(
    parameter int ADDR_W = 32,
    parameter int WORD_W = 32,
    parameter int LINES  = 1024,
    parameter int WORDS  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              resp_valid,
    output logic [WORD_W-1:0] resp_data,
    output logic [1:0]        resp_kind,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_rvalid,
    input  logic [WORD_W-1:0] mem_rdata
);
    localparam int IDX_W  = $clog2(LINES);
    localparam int WSEL_W = $clog2(WORDS);
    localparam int BYTE_W = $clog2(WORD_W / 8);
    localparam int TAG_W  = ADDR_W - IDX_W - WSEL_W - BYTE_W;
    localparam int LINE_W = WORDS * WORD_W;

    logic [ADDR_W-1:0] addr_q;
    logic [TAG_W-1:0]  a_tag;
    logic [IDX_W-1:0]  a_idx;
    logic [WSEL_W-1:0] a_wsel;
    logic              line_valid;
    logic [TAG_W-1:0]  line_tag;
    logic              line_hit;
    logic [LINE_W-1:0] rd_line;
    logic [LINE_W-1:0] wr_line;
    logic [WORD_W-1:0] fill_buf [WORDS];
    logic              take_req;
    logic              beat_take;
    logic              install;
    logic [WSEL_W-1:0] beat;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else if (take_req) begin
            addr_q <= req_addr;
        end
    end

    dmc_addr_split #(
        .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W), .BYTE_W(BYTE_W), .TAG_W(TAG_W)
    ) u_split (
        .addr(addr_q), .tag(a_tag), .idx(a_idx), .wsel(a_wsel)
    );

    dmc_tag_store #(.LINES(LINES), .TAG_W(TAG_W), .IDX_W(IDX_W)) u_tags (
        .clk(clk), .rst_n(rst_n),
        .rd_idx(a_idx), .rd_valid(line_valid), .rd_tag(line_tag),
        .wr_en(install), .wr_idx(a_idx), .wr_tag(a_tag)
    );

    dmc_line_store #(.LINES(LINES), .LINE_W(LINE_W), .IDX_W(IDX_W)) u_lines (
        .clk(clk),
        .rd_idx(a_idx), .rd_line(rd_line),
        .wr_en(install), .wr_idx(a_idx), .wr_line(wr_line)
    );

    assign line_hit = line_valid && (line_tag == a_tag);

    dmc_fsm #(.WORDS(WORDS), .BEAT_W(WSEL_W)) u_fsm (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .line_hit(line_hit), .line_valid(line_valid),
        .mem_rvalid(mem_rvalid),
        .req_ready(req_ready), .take_req(take_req),
        .resp_valid(resp_valid), .resp_kind(resp_kind),
        .mem_rd(mem_rd), .beat_take(beat_take), .install(install), .beat(beat)
    );

    // Earlier beats are buffered; the final beat goes straight into the line.
    always_ff @(posedge clk) begin
        if (beat_take) begin
            fill_buf[beat] <= mem_rdata;
        end
    end

    for (genvar g = 0; g < WORDS; g++) begin : g_fill
        if (g == WORDS - 1) begin : g_last
            assign wr_line[g*WORD_W +: WORD_W] = mem_rdata;
        end else begin : g_buf
            assign wr_line[g*WORD_W +: WORD_W] = fill_buf[g];
        end
    end

    assign mem_addr  = {a_tag, a_idx, beat, {BYTE_W{1'b0}}};
    assign resp_data = rd_line[a_wsel*WORD_W +: WORD_W];

endmodule

// File: rtl/dmc_checker.sv
module dmc_checker #(
    parameter int ADDR_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_ready,
    input logic              resp_valid,
    input logic [1:0]        resp_kind,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_rvalid
);
    p_hit_next_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind == 2'b00) |-> $past(req_valid && req_ready));

    p_miss_after_refill_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid && resp_kind != 2'b00) |-> $past(mem_rvalid && mem_rd));

    p_kind_legal_r5: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_kind != 2'b11));

    p_fill_stalls_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> !req_ready);

    p_addr_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !mem_rvalid) |=> (mem_rd && $stable(mem_addr)));

    p_word_aligned_r6: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd |-> (mem_addr[1:0] == 2'b00));

    p_resp_blocks_req_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> !req_ready);

    p_resp_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |=> !resp_valid);

endmodule

bind dm_read_cache dmc_checker #(.ADDR_W(ADDR_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .resp_valid(resp_valid), .resp_kind(resp_kind), .mem_rd(mem_rd),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid)
);

// File: tb/sim_dm_read_cache.sv
module sim_dm_read_cache;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        req_valid;
    logic        req_ready;
    logic [31:0] req_addr;
    logic        resp_valid;
    logic [31:0] resp_data;
    logic [1:0]  resp_kind;
    logic        mem_rd;
    logic [31:0] mem_addr;
    logic        mem_rvalid;
    logic [31:0] mem_rdata;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    int beat_total = 0;
    logic [31:0] beat_log [64];

    always #5 clk = ~clk;

    dm_read_cache u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .resp_valid(resp_valid), .resp_data(resp_data),
        .resp_kind(resp_kind), .mem_rd(mem_rd), .mem_addr(mem_addr),
        .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata)
    );

    function automatic logic [31:0] mem_word(input logic [31:0] a);
        return ({a[31:2], 2'b00} * 32'h9E37_79B9) ^ 32'h5A5A_1234;
    endfunction

    // Backing memory: answers each pending read one cycle later.
    always @(posedge clk) begin
        if (!rst_n) begin
            mem_rvalid <= 1'b0;
            mem_rdata  <= '0;
            beat_total <= 0;
        end else begin
            mem_rvalid <= mem_rd && !mem_rvalid;
            mem_rdata  <= mem_word(mem_addr);
            if (mem_rd && mem_rvalid) begin
                beat_log[beat_total % 64] <= mem_addr;
                beat_total <= beat_total + 1;
            end
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            errors = errors + 1;
            $display("FAIL watchdog act=%0d exp=<100000", cycles);
            summary();
            $finish;
        end
    end

    task automatic ck(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", rq, act, exp);
        end
    endtask

    // One access: present, wait for acceptance, wait for the response, check it.
    task automatic do_read(input logic [31:0] a, input logic [1:0] ek, input string rq);
        int b0;
        int cyc;
        logic r;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        r = req_ready;
        while (!r) begin
            @(negedge clk);
            r = req_ready;
        end
        b0 = beat_total;
        @(negedge clk);
        req_valid = 1'b0;
        cyc = 1;
        while (!resp_valid && cyc < 200) begin
            @(negedge clk);
            cyc++;
        end
        ck(resp_valid == 1'b1, {rq, " response seen"}, 32'(resp_valid), 32'd1);
        ck(resp_data == mem_word(a), {rq, " R7 data"}, resp_data, mem_word(a));
        ck(resp_kind == ek, {rq, " kind"}, 32'(resp_kind), 32'(ek));
        ck(req_ready == 1'b0, {rq, " R9 ready low at response"}, 32'(req_ready), 32'd0);
        if (ek == 2'b00) begin
            ck(cyc == 1, {rq, " R3 latency"}, 32'(cyc), 32'd1);
            ck(beat_total == b0, {rq, " R3 no memory read"}, 32'(beat_total - b0), 32'd0);
        end else begin
            ck(beat_total - b0 == 4, {rq, " R6 beat count"}, 32'(beat_total - b0), 32'd4);
            for (int k = 0; k < 4; k++) begin
                ck(beat_log[(b0 + k) % 64] == {a[31:4], 4'h0} + 32'(4 * k), {rq, " R6 beat order"},
                   beat_log[(b0 + k) % 64], {a[31:4], 4'h0} + 32'(4 * k));
            end
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        ck(req_ready == 1'b1, "R1 ready after reset", 32'(req_ready), 32'd1);
        ck(resp_valid == 1'b0, "R1 no response after reset", 32'(resp_valid), 32'd0);
        ck(mem_rd == 1'b0, "R1 no memory read after reset", 32'(mem_rd), 32'd0);
    endtask

    task automatic t_cold_then_hits();
        do_read(32'h0000_0014, 2'b01, "R1 R4 cold miss index 1");
        do_read(32'h0000_0010, 2'b00, "R4 R8 hit word 0");
        do_read(32'h0000_0017, 2'b00, "R8 low bits ignored word 1");
        do_read(32'h0000_001A, 2'b00, "R8 word 2");
        do_read(32'h0000_001F, 2'b00, "R3 R8 word 3");
    endtask

    task automatic t_other_index();
        do_read(32'h0000_003C, 2'b01, "R2 cold miss index 3");
        do_read(32'h0000_0014, 2'b00, "R2 index 1 undisturbed");
    endtask

    task automatic t_conflict();
        do_read(32'h0000_8014, 2'b10, "R2 R5 replace tag 2");
        do_read(32'h0000_0014, 2'b10, "R5 old tag replaced again");
        do_read(32'h0000_801C, 2'b10, "R5 ping-pong");
        do_read(32'h0000_8018, 2'b00, "R5 new line hits");
        do_read(32'h0000_0038, 2'b00, "R2 index 3 undisturbed");
    endtask

    task automatic t_edges();
        do_read(32'hFFFF_FFF0, 2'b01, "R2 top index max tag");
        do_read(32'hFFFF_FFFD, 2'b00, "R8 top word hit");
        do_read(32'h0000_0000, 2'b01, "R2 index 0");
        do_read(32'hFFFF_C008, 2'b10, "R5 index 0 max tag");
        do_read(32'hFFFF_C000, 2'b00, "R7 index 0 word 0");
    endtask

    // Next request held across a refill and its response.
    task automatic t_held();
        logic [31:0] a;
        int cyc;
        int early;
        a = 32'h0000_5550;
        early = 0;
        @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        @(negedge clk);
        req_addr = a + 32'd8;
        cyc = 0;
        while (!resp_valid && cyc < 200) begin
            if (req_ready) early++;
            @(negedge clk);
            cyc++;
        end
        ck(early == 0, "R9 held request stalled during refill", 32'(early), 32'd0);
        ck(resp_kind == 2'b01, "R4 held case cold miss", 32'(resp_kind), 32'd1);
        ck(resp_data == mem_word(a), "R7 held case first data", resp_data, mem_word(a));
        ck(req_ready == 1'b0, "R9 ready low at response", 32'(req_ready), 32'd0);
        @(negedge clk);
        ck(resp_valid == 1'b0, "R9 response is a pulse", 32'(resp_valid), 32'd0);
        ck(req_ready == 1'b1, "R9 held request accepted after response", 32'(req_ready), 32'd1);
        @(negedge clk);
        req_valid = 1'b0;
        ck(resp_valid == 1'b1, "R3 held request answered next cycle", 32'(resp_valid), 32'd1);
        ck(resp_kind == 2'b00, "R3 held request hits", 32'(resp_kind), 32'd0);
        ck(resp_data == mem_word(a + 32'd8), "R7 held request data", resp_data, mem_word(a + 32'd8));
    endtask

    initial begin
        rst_n     = 1'b0;
        req_valid = 1'b0;
        req_addr  = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_cold_then_hits();
        t_other_index();
        t_conflict();
        t_edges();
        t_held();
        repeat (3) @(negedge clk);
        summary();
        $finish;
    end

endmodule